// File: doc/BRIEF.md
# CPU Clock Source and Divider Control

This block turns a chosen oscillator into the CPU clock of a small microcontroller core. Each oscillator is modelled as a one-cycle enable strobe in the fast system clock domain. The block produces enable pulses, not a gated clock. A static configuration code picks the default oscillator. A bit in the trim/select register can force the internal RC oscillator at any time, without a reset. The active strobe is then divided by a programmable even factor to form the CPU clock enable. A peripheral clock enable runs at half that rate. A clock-out pin can toggle at half the CPU clock rate.

After any reset, and after every wake-up request, the block holds the CPU clock off. First it counts a fixed number of strobes from the active oscillator, and that number depends on the oscillator kind. It then waits a fixed number of system clock cycles for settling. Software reaches the block through a small write port that holds two registers: the trim/select register and the divider register. The six low trim bits are passed out unchanged to the analog trim logic. They are loaded from a calibration input only at power-on.

Top module: `cpu_clk_ctrl`

## Requirements
- R1: With divider value N greater than 0, `cclk_en` pulses once for every 2N strobes of the active oscillator. The slowest rate is one pulse per 510 strobes.
- R2: With divider value 0, `cclk_en` pulses once for every strobe of the active oscillator. Each pulse appears one cycle after its strobe.
- R3: The divider register (write with `wr_sel`=1) may be rewritten while running, with no reset. If the count already reached is at or beyond the new limit, the next active strobe produces a pulse.
- R4: Trim bit 7 (write with `wr_sel`=0), when set, makes the RC oscillator (`rc_tick`) active in place of the configured one. The active source changes only when the divider count is at the start of a period. The strobe in the cycle of the change is discarded, so no CPU period is shortened.
- R5: When trim bit 6 is set and the active source is not the crystal (`cfg_src`=00), `clkout` toggles on every `cclk_en` pulse. Otherwise `clkout` is held low.
- R6: Trim bits 5:0 are loaded from `cal_value` only while `por_n` is low. A reset through `rst_n` alone leaves them unchanged. Either reset clears trim bits 7:6 and the divider register.
- R7: After reset release, or after a `wake` pulse, the hold-off counts active strobes. It counts 992 strobes for `cfg_src` code 00 (crystal) and 224 strobes for codes 01 (RC), 10 (watchdog oscillator, `wdo_tick`) and 11 (external clock on `xtal_tick`). It then waits SETTLE_CYCLES (default 16) system cycles. With a strobe in every cycle and divider 0, the first `cclk_en` follows hold + SETTLE_CYCLES + 1 edges after release.
- R8: `pclk_en` pulses together with every second `cclk_en` pulse, starting with the second pulse after reset.
- R9: `holding` is high for the whole hold-off. `cclk_en` stays low whenever `holding` has been high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all strobes are sampled on it |
| rst_n | input | 1 | Synchronous active-low system reset |
| por_n | input | 1 | Synchronous active-low power-on reset |
| cal_value | input | 6 | Stored calibration code, loaded into trim bits 5:0 on power-on |
| cfg_src | input | 2 | Configured oscillator: 00 crystal, 01 RC, 10 watchdog, 11 external |
| xtal_tick | input | 1 | Crystal or external clock strobe |
| rc_tick | input | 1 | Internal RC oscillator strobe |
| wdo_tick | input | 1 | Watchdog oscillator strobe |
| wake | input | 1 | Wake-up request; restarts the hold-off |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects trim/select register, 1 selects divider |
| wr_data | input | 8 | Register write data |
| cclk_en | output | 1 | CPU clock enable pulse |
| pclk_en | output | 1 | Peripheral clock enable pulse |
| clkout | output | 1 | Clock output at half the CPU clock rate |
| holding | output | 1 | High while the wake-up hold-off runs |
| trim_code | output | 6 | Trim field driven to the oscillator trimming |

## Verification
Two functions can land in the same cycle. A request to switch source can be pending while the divider sits at a period start and a strobe of the old source arrives. The bench provokes this by setting trim bit 7 while the crystal strobes every cycle and the divider is running, and by random trim writes under random strobe densities. It judges the result by checking that no gap between CPU pulses is shorter than one full old period, and by comparing every cycle against a reference model. A wake pulse or a divider write that arrives while a pulse is being produced is covered the same way by the random phase.

// File: rtl/ccd_pkg.sv
// Shared types for the CPU clock source and divider control.
package ccd_pkg;
    // Oscillator source codes; 00 is the crystal, the only source with the long hold-off.
    typedef enum logic [1:0] {
        SRC_XTAL = 2'b00,
        SRC_RC   = 2'b01,
        SRC_WDO  = 2'b10,
        SRC_EXT  = 2'b11
    } src_t;

    // Phases of the wake-up hold-off.
    typedef enum logic [1:0] {
        PH_OSC    = 2'b00,
        PH_SETTLE = 2'b01,
        PH_RUN    = 2'b10
    } hold_t;
endpackage

// File: rtl/ccd_regs.sv
// Trim/select and divider registers.
// The calibration field is loaded only on power-on reset. A system reset clears
// the control bits and the divider but keeps the calibration field.
// Assumes por_n and rst_n are synchronous and active low.
module ccd_regs #(
    parameter int REG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             por_n,
    input  logic [REG_W-3:0] cal_value,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] trim_q,
    output logic [REG_W-1:0] divm_q
);
    // Register update: power-on load, system reset clear, software write.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            trim_q <= {2'b00, cal_value};
            divm_q <= '0;
        end else if (!rst_n) begin
            trim_q[REG_W-1:REG_W-2] <= 2'b00;
            divm_q                  <= '0;
        end else if (wr_en) begin
            if (wr_sel) divm_q <= wr_data;
            else        trim_q <= wr_data;
        end
    end
endmodule

// File: rtl/ccd_src_sel.sv
// Source selection. Picks the active oscillator strobe.
// A source change requested by the RC override is applied only when the
// divider reports a period boundary. The strobe of the switching cycle is dropped.
module ccd_src_sel
    import ccd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  src_t       cfg_src,
    input  logic       rc_override,
    input  logic       at_boundary,
    input  logic       xtal_tick,
    input  logic       rc_tick,
    input  logic       wdo_tick,
    output src_t       act_src,
    output logic       act_tick
);
    localparam int NSRC = 4;

    logic [NSRC-1:0] tick_vec;
    src_t            req_src;
    logic            do_switch;

    // Map each source code to its strobe pin; the external clock shares the crystal pin.
    for (genvar gi = 0; gi < NSRC; gi++) begin : g_map
        if (gi == 1) begin : g_rc
            assign tick_vec[gi] = rc_tick;
        end else if (gi == 2) begin : g_wdo
            assign tick_vec[gi] = wdo_tick;
        end else begin : g_xtal
            assign tick_vec[gi] = xtal_tick;
        end
    end

    // Requested source and the boundary-qualified switch decision.
    always_comb begin
        req_src   = rc_override ? SRC_RC : cfg_src;
        do_switch = (req_src != act_src) && at_boundary;
        act_tick  = tick_vec[act_src] && !do_switch;
    end

    // Active source register.
    always_ff @(posedge clk) begin
        if (!rst_n)         act_src <= cfg_src;
        else if (do_switch) act_src <= req_src;
    end
endmodule

// File: rtl/ccd_holdoff.sv
// Wake-up hold-off. Counts active strobes up to a source-dependent limit, then
// waits a fixed number of system cycles before letting the divider run.
// Restarts on reset and on every wake request.
module ccd_holdoff
    import ccd_pkg::*;
#(
    parameter int LONG_HOLD     = 992,
    parameter int SHORT_HOLD    = 224,
    parameter int SETTLE_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wake,
    input  src_t act_src,
    input  logic act_tick,
    output logic run,
    output logic holding
);
    localparam int MAXH = (LONG_HOLD > SHORT_HOLD) ? LONG_HOLD : SHORT_HOLD;
    localparam int HW   = $clog2(MAXH + 1);
    localparam int SW   = $clog2(SETTLE_CYCLES + 1);

    hold_t          phase;
    logic [HW-1:0]  hcnt;
    logic [HW-1:0]  hlim;
    logic [SW-1:0]  scnt;

    // Last strobe count of the oscillator phase for the active source.
    always_comb begin
        hlim = (act_src == SRC_XTAL) ? HW'(LONG_HOLD - 1) : HW'(SHORT_HOLD - 1);
    end

    // Hold-off sequencing: oscillator count, settle count, run.
    always_ff @(posedge clk) begin
        if (!rst_n || wake) begin
            phase <= PH_OSC;
            hcnt  <= '0;
            scnt  <= '0;
        end else begin
            case (phase)
                PH_OSC: begin
                    if (act_tick) begin
                        if (hcnt == hlim) begin
                            phase <= PH_SETTLE;
                            scnt  <= '0;
                        end else begin
                            hcnt <= hcnt + HW'(1);
                        end
                    end
                end
                PH_SETTLE: begin
                    if (scnt == SW'(SETTLE_CYCLES - 1)) phase <= PH_RUN;
                    else                                scnt  <= scnt + SW'(1);
                end
                default: phase <= PH_RUN;
            endcase
        end
    end

    assign run     = (phase == PH_RUN);
    assign holding = !run;
endmodule

// File: rtl/ccd_divider.sv
// Even-factor divider. Makes one CPU enable per 2N active strobes, or one per
// strobe when N is 0. Also makes the half-rate peripheral enable and the
// toggling clock output.
// Assumes the divider value may change at any cycle.
module ccd_divider #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             act_tick,
    input  logic [DIV_W-1:0] divm,
    input  logic             clkout_en,
    output logic             cclk_en,
    output logic             pclk_en,
    output logic             clkout,
    output logic             at_boundary
);
    localparam int CW = DIV_W + 1;

    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;
    logic          fire;
    logic          pphase;

    // Period limit 2N-1 and the fire decision; >= keeps a shrunk limit from stalling.
    always_comb begin
        lim  = {divm, 1'b0} - CW'(1);
        fire = run && act_tick && ((divm == '0) || (cnt >= lim));
    end

    // Strobe counter and registered enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            cclk_en <= 1'b0;
            pclk_en <= 1'b0;
            pphase  <= 1'b0;
            clkout  <= 1'b0;
        end else begin
            if (!run)          cnt <= '0;
            else if (act_tick) cnt <= fire ? '0 : cnt + CW'(1);
            cclk_en <= fire;
            pclk_en <= fire && pphase;
            if (fire) pphase <= !pphase;
            if (!clkout_en) clkout <= 1'b0;
            else if (fire)  clkout <= !clkout;
        end
    end

    assign at_boundary = (cnt == '0);
endmodule

// File: rtl/cpu_clk_ctrl.sv
// Top of the CPU clock source and divider control.
// All oscillators arrive as enable strobes on clk. The outputs are enable
// pulses on clk plus a toggling clock-out level.
// Assumes cfg_src changes only while a reset is held.
module cpu_clk_ctrl
    import ccd_pkg::*;
#(
    parameter int REG_W         = 8,
    parameter int LONG_HOLD     = 992,
    parameter int SHORT_HOLD    = 224,
    parameter int SETTLE_CYCLES = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             por_n,
    input  logic [REG_W-3:0] cal_value,
    input  logic [1:0]       cfg_src,
    input  logic             xtal_tick,
    input  logic             rc_tick,
    input  logic             wdo_tick,
    input  logic             wake,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [REG_W-1:0] wr_data,
    output logic             cclk_en,
    output logic             pclk_en,
    output logic             clkout,
    output logic             holding,
    output logic [REG_W-3:0] trim_code
);
    localparam int RC_BIT  = REG_W - 1;
    localparam int OUT_BIT = REG_W - 2;

    logic             sys_rst_n;
    logic [REG_W-1:0] trim_q;
    logic [REG_W-1:0] divm_q;
    src_t             act_src;
    logic             act_tick;
    logic             at_boundary;
    logic             run;
    logic             clkout_en;

    assign sys_rst_n = rst_n && por_n;
    assign trim_code = trim_q[REG_W-3:0];
    assign clkout_en = trim_q[OUT_BIT] && (act_src != SRC_XTAL);

    ccd_regs #(.REG_W(REG_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .por_n     (por_n),
        .cal_value (cal_value),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .trim_q    (trim_q),
        .divm_q    (divm_q)
    );

    ccd_src_sel u_sel (
        .clk         (clk),
        .rst_n       (sys_rst_n),
        .cfg_src     (src_t'(cfg_src)),
        .rc_override (trim_q[RC_BIT]),
        .at_boundary (at_boundary),
        .xtal_tick   (xtal_tick),
        .rc_tick     (rc_tick),
        .wdo_tick    (wdo_tick),
        .act_src     (act_src),
        .act_tick    (act_tick)
    );

    ccd_holdoff #(
        .LONG_HOLD     (LONG_HOLD),
        .SHORT_HOLD    (SHORT_HOLD),
        .SETTLE_CYCLES (SETTLE_CYCLES)
    ) u_hold (
        .clk      (clk),
        .rst_n    (sys_rst_n),
        .wake     (wake),
        .act_src  (act_src),
        .act_tick (act_tick),
        .run      (run),
        .holding  (holding)
    );

    ccd_divider #(.DIV_W(REG_W)) u_div (
        .clk         (clk),
        .rst_n       (sys_rst_n),
        .run         (run),
        .act_tick    (act_tick),
        .divm        (divm_q),
        .clkout_en   (clkout_en),
        .cclk_en     (cclk_en),
        .pclk_en     (pclk_en),
        .clkout      (clkout),
        .at_boundary (at_boundary)
    );
endmodule

// File: rtl/cpu_clk_ctrl_chk.sv
// Property checker for cpu_clk_ctrl. It is attached to every instance by bind.
// It watches ports plus the active source and the divider boundary flag.
module cpu_clk_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       por_n,
    input logic       wr_en,
    input logic       wr_sel,
    input logic       cclk_en,
    input logic       pclk_en,
    input logic       clkout,
    input logic       holding,
    input logic [5:0] trim_code,
    input logic [1:0] act_src,
    input logic       at_boundary
);
    // R9: no CPU enable once the hold-off has lasted two cycles.
    a_r9_quiet_in_hold: assert property (@(posedge clk) disable iff (!(rst_n && por_n))
        (holding && $past(holding)) |-> !cclk_en);

    // R8: a peripheral enable never stands without a CPU enable.
    a_r8_pclk_within_cclk: assert property (@(posedge clk) disable iff (!(rst_n && por_n))
        pclk_en |-> cclk_en);

    // R5: clkout only rises together with a CPU enable.
    a_r5_clkout_rise: assert property (@(posedge clk) disable iff (!(rst_n && por_n))
        $rose(clkout) |-> cclk_en);

    // R6: the calibration field changes only through a trim write or power-on.
    a_r6_trim_kept: assert property (@(posedge clk) disable iff (!por_n)
        !($past(wr_en) && !$past(wr_sel)) |-> (trim_code == $past(trim_code)));

    // R4: the active source changes only from a divider period boundary.
    a_r4_switch_on_boundary: assert property (@(posedge clk) disable iff (!(rst_n && por_n))
        (act_src != $past(act_src)) |-> $past(at_boundary));
endmodule

bind cpu_clk_ctrl cpu_clk_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .por_n       (por_n),
    .wr_en       (wr_en),
    .wr_sel      (wr_sel),
    .cclk_en     (cclk_en),
    .pclk_en     (pclk_en),
    .clkout      (clkout),
    .holding     (holding),
    .trim_code   (trim_code),
    .act_src     (act_src),
    .at_boundary (at_boundary)
);

// File: tb/cpu_clk_ctrl_tb.sv
// Bench for cpu_clk_ctrl: directed corner cases plus seeded random phase.
// Every cycle is also compared against a behavioural reference model.
module cpu_clk_ctrl_tb;
    localparam int LONG_H = 992;
    localparam int SHORT_H = 224;
    localparam int SETTLE = 16;
    localparam logic [5:0] CAL = 6'h2A;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst_n = 1'b0, por_n = 1'b0;
    logic [5:0] cal_value = CAL;
    logic [1:0] cfg_src = 2'b01;
    logic       xtal_tick = 1'b0, rc_tick = 1'b0, wdo_tick = 1'b0;
    logic       wake = 1'b0, wr_en = 1'b0, wr_sel = 1'b0;
    logic [7:0] wr_data = '0;
    logic       cclk_en, pclk_en, clkout, holding;
    logic [5:0] trim_code;

    int n_tests = 0, n_fail = 0;
    bit cmp_on = 1'b0;
    bit use_rand = 1'b0;
    int per_x = 1, per_r = 1, per_w = 1, cyc = 0;

    cpu_clk_ctrl #(.LONG_HOLD(LONG_H), .SHORT_HOLD(SHORT_H), .SETTLE_CYCLES(SETTLE)) u_dut (
        .clk(clk), .rst_n(rst_n), .por_n(por_n), .cal_value(cal_value), .cfg_src(cfg_src),
        .xtal_tick(xtal_tick), .rc_tick(rc_tick), .wdo_tick(wdo_tick), .wake(wake),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .cclk_en(cclk_en),
        .pclk_en(pclk_en), .clkout(clkout), .holding(holding), .trim_code(trim_code));

    function automatic bit f_tick(logic [1:0] s, logic x, logic r, logic w);
        return (s == 2'd1) ? r : (s == 2'd2) ? w : x;
    endfunction
    function automatic int f_hold(logic [1:0] s);
        return (s == 2'd0) ? LONG_H : SHORT_H;
    endfunction

    // Reference model state
    logic [1:0] m_act; int m_cnt, m_phase, m_h, m_s;
    bit m_pp, m_ck, m_cclk, m_pclk;
    logic [7:0] m_trim, m_div;

    // Reference model, one step per clock edge
    always @(posedge clk) begin : model
        logic [1:0] req; bit sw, tk, run, fire;
        if (!por_n || !rst_n) begin
            if (!por_n) m_trim <= {2'b00, cal_value}; else m_trim[7:6] <= 2'b00;
            m_div <= '0; m_act <= cfg_src; m_cnt <= 0; m_phase <= 0; m_h <= 0; m_s <= 0;
            m_pp <= 0; m_ck <= 0; m_cclk <= 0; m_pclk <= 0;
        end else begin
            req  = m_trim[7] ? 2'd1 : cfg_src;
            sw   = (req != m_act) && (m_cnt == 0);
            tk   = !sw && f_tick(m_act, xtal_tick, rc_tick, wdo_tick);
            run  = (m_phase == 2);
            fire = run && tk && (m_div == 0 || m_cnt >= 2 * int'(m_div) - 1);
            if (wr_en) begin
                if (wr_sel) m_div <= wr_data; else m_trim <= wr_data;
            end
            if (sw) m_act <= req;
            if (wake) begin m_phase <= 0; m_h <= 0; m_s <= 0; end
            else if (m_phase == 0) begin
                if (tk) begin
                    if (m_h == f_hold(m_act) - 1) begin m_phase <= 1; m_s <= 0; end
                    else m_h <= m_h + 1;
                end
            end else if (m_phase == 1) begin
                if (m_s == SETTLE - 1) m_phase <= 2; else m_s <= m_s + 1;
            end
            if (!run) m_cnt <= 0; else if (tk) m_cnt <= fire ? 0 : m_cnt + 1;
            m_cclk <= fire; m_pclk <= fire && m_pp;
            if (fire) m_pp <= !m_pp;
            if (!(m_trim[6] && m_act != 2'd0)) m_ck <= 0; else if (fire) m_ck <= !m_ck;
        end
    end

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Strobe generation and per-cycle model comparison, away from the active edge
    always @(negedge clk) begin
        cyc++;
        if (use_rand) begin
            xtal_tick = ($urandom % 100) < 45; rc_tick = ($urandom % 100) < 60;
            wdo_tick = ($urandom % 100) < 30;
        end else begin
            xtal_tick = (cyc % per_x) == 0; rc_tick = (cyc % per_r) == 0;
            wdo_tick = (cyc % per_w) == 0;
        end
        if (cmp_on) begin
            check(cclk_en === m_cclk, "R1", "model cclk_en", cclk_en, m_cclk);
            check(pclk_en === m_pclk, "R8", "model pclk_en", pclk_en, m_pclk);
            check(clkout === m_ck, "R5", "model clkout", clkout, m_ck);
            check(holding === (m_phase != 2), "R9", "model holding", holding, m_phase != 2);
            check(trim_code === m_trim[5:0], "R6", "model trim_code", trim_code, m_trim[5:0]);
        end
    end

    task automatic do_por(logic [1:0] cfg);
        @(negedge clk); por_n = 0; rst_n = 0; cfg_src = cfg;
        repeat (3) @(negedge clk);
        por_n = 1; rst_n = 1;
    endtask

    task automatic wr(bit sel, logic [7:0] d);
        @(negedge clk); wr_en = 1; wr_sel = sel; wr_data = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic wait_first(output int n);
        n = 0;
        while (!cclk_en && n < 4000) begin @(posedge clk); n++; @(negedge clk); end
    endtask

    task automatic count_win(int cycles, output int nc, output int np, output int nt, output int mingap);
        bit prev; int last;
        nc = 0; np = 0; nt = 0; mingap = 1 << 30; last = -1; prev = clkout;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (cclk_en) begin
                if (last >= 0 && (i - last) < mingap) mingap = i - last;
                last = i; nc++;
            end
            np += pclk_en;
            if (clkout != prev) nt++;
            prev = clkout;
        end
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : stim
        int n, nc, np, nt, mg;
        void'($urandom(32'h5eed_0c1c));
        // Reset state (R6, R9)
        repeat (3) @(negedge clk);
        cmp_on = 1;
        check(cclk_en == 0 && clkout == 0, "R9", "reset outputs quiet", cclk_en, 0);
        check(holding == 1, "R9", "holding in reset", holding, 1);
        check(trim_code == CAL, "R6", "cal loaded on power-on", trim_code, CAL);
        // RC hold-off, strobe every cycle (R7), then undivided rate (R2)
        per_r = 1;
        por_n = 1; rst_n = 1;
        wait_first(n);
        check(n == SHORT_H + SETTLE + 1, "R7", "RC hold-off edges", n, SHORT_H + SETTLE + 1);
        count_win(50, nc, np, nt, mg);
        check(nc == 50, "R2", "undivided pulses", nc, 50);
        // Divide by 6 (R1) and peripheral rate (R8)
        wr(1, 8'd3);
        repeat (10) @(negedge clk);
        count_win(600, nc, np, nt, mg);
        check(nc == 100, "R1", "N=3 pulses in 600", nc, 100);
        check(np == 50, "R8", "pclk pulses in 600", np, 50);
        // Clock out on RC (R5)
        wr(0, {2'b01, CAL});
        repeat (10) @(negedge clk);
        count_win(600, nc, np, nt, mg);
        check(nt == 100, "R5", "clkout toggles", nt, 100);
        // System reset keeps calibration, clears control bits (R6)
        wr(0, {2'b01, 6'h15});
        @(negedge clk); rst_n = 0; repeat (3) @(negedge clk); rst_n = 1;
        check(trim_code == 6'h15, "R6", "trim kept over rst_n", trim_code, 6'h15);
        wait_first(n);
        count_win(300, nc, np, nt, mg);
        check(nt == 0 && clkout == 0, "R6", "clkout bit cleared by rst_n", nt, 0);
        do_por(2'b00);
        @(negedge clk);
        check(trim_code == CAL, "R6", "cal reloaded on power-on", trim_code, CAL);
        // Crystal hold-off (R7), then crystal blocks clkout (R5)
        per_x = 1;
        wait_first(n);
        check(n == LONG_H + SETTLE, "R7", "crystal hold-off edges after first cycle", n, LONG_H + SETTLE);
        wr(1, 8'd4);
        wr(0, {2'b01, CAL});
        count_win(200, nc, np, nt, mg);
        check(nt == 0, "R5", "no clkout on crystal", nt, 0);
        check(nc == 25, "R1", "N=4 crystal pulses in 200", nc, 25);
        // On-the-fly switch to RC at half rate (R4)
        per_r = 2;
        wr(0, {2'b11, CAL});
        count_win(400, nc, np, nt, mg);
        check(mg >= 8, "R4", "min gap across switch", mg, 8);
        count_win(400, nc, np, nt, mg);
        check(nc == 25, "R4", "RC half-rate pulses", nc, 25);
        check(nt == 25, "R5", "clkout toggles after switch", nt, 25);
        // Divider rewrite while running (R3)
        wr(1, 8'd1);
        count_win(20, nc, np, nt, mg);
        check(nc >= 1, "R3", "pulse soon after shrink", nc, 1);
        count_win(400, nc, np, nt, mg);
        check(nc == 100, "R3", "new rate applied", nc, 100);
        // Wake restarts hold-off (R7, R9)
        @(negedge clk); wake = 1; @(negedge clk); wake = 0;
        check(holding == 1, "R9", "holding after wake", holding, 1);
        count_win(400, nc, np, nt, mg);
        check(nc == 0, "R9", "quiet during hold-off", nc, 0);
        wait_first(n);
        check(cclk_en == 1, "R7", "clock resumes after wake", cclk_en, 1);
        // Random phase against the model
        for (int k = 0; k < 3; k++) begin
            do_por(2'($urandom % 4));
            use_rand = 1;
            for (int c = 0; c < 6000; c++) begin
                @(negedge clk);
                wr_en = 0; wake = 0;
                if (($urandom % 40) == 0) begin
                    wr_en = 1; wr_sel = $urandom % 2;
                    wr_data = wr_sel ? 8'($urandom % 6) : 8'($urandom);
                end else if (($urandom % 500) == 0) wake = 1;
            end
            @(negedge clk); wr_en = 0; wake = 0;
            use_rand = 0;
        end
        repeat (5) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule